// File: doc/BRIEF.md
# Masked Vector Element Executor

This block runs one elementwise integer operation over a vector of up to 64 elements, one element per cycle, under a per-element enable mask that it holds itself. The two source vectors live outside the block: it presents an element index, and the register file returns operand A and operand B for that index in the same cycle. Arithmetic results leave through a destination write port that carries an index, a data word and a strobe. Compare results do not leave the block. They are written into the mask, one bit per element.

A mode input picks one of two timings for arithmetic. In the full-sweep timing, every element below the vector length takes one cycle, and a disabled element produces no strobe. In the skipping timing, the block walks only the enabled elements, in ascending order. It takes one cycle per enabled element, or a single cycle when no element is enabled. Compares and the mask fill ignore the mode.

Top module: `vme_executor`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `wr_en_o` are 0, and `mask_o` is all ones.
- R2: Op code 0 writes A+B and op code 1 writes A−B, both modulo 2^DATA_W. A write happens for element i only when i < VL and mask bit i is 1. Each write sets `wr_en_o` with `wr_idx_o`=i and `wr_data_o` set to the result. Arithmetic leaves the mask unchanged.
- R3: With `dense_i`=0, an arithmetic op with VL≥1 spends exactly VL busy cycles, visiting elements 0..VL−1 in order. `done_o` is high for one cycle, on the last busy cycle, and `busy_o` falls on the next cycle.
- R4: With `dense_i`=1, an arithmetic op spends exactly one busy cycle per enabled element below VL. It writes in every one of those cycles, with strictly ascending indices.
- R5: With `dense_i`=1, an arithmetic op that has no enabled element below VL completes in one cycle with no write. Any op with VL=0 also completes in one cycle with no write.
- R6: Op code 2 (signed A > B) and op code 3 (A == B) set mask bit i to the result for every i < VL, whatever the old mask bit. They take max(VL,1) cycles in both modes and make no data write. Mask bits at i ≥ VL keep their value.
- R7: Op code 4 sets every mask bit to 1 in a single busy cycle, with no data write.
- R8: Mask bits at or above VL have no effect. A `vlen_i` above 64 behaves as 64.
- R9: A start request while the block is busy is ignored, including one in the cycle that raises `done_o`. Op codes 5 to 7 complete in one cycle with no write and with the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled only when idle |
| op_i | input | 3 | Operation code (see R2, R6, R7, R9) |
| dense_i | input | 1 | 1 = skip disabled elements for arithmetic |
| vlen_i | input | 7 | Vector length, clamped to 64 |
| src_idx_o | output | 6 | Element index presented to the source file |
| src_a_i | input | 16 | Operand A for `src_idx_o` |
| src_b_i | input | 16 | Operand B for `src_idx_o` |
| wr_en_o | output | 1 | Destination write strobe |
| wr_idx_o | output | 6 | Destination element index |
| wr_data_o | output | 16 | Destination data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last busy cycle of an operation |
| mask_o | output | 64 | Current element mask |

## Verification
The clash that matters is a new start request landing in the completion cycle, when `done_o` is high but the block has not yet gone idle. The bench drives `start_i` for exactly that one cycle. It then judges that, on the following cycle, `busy_o` stays low and no write appears. A second overlap is a compare rewriting a mask bit while the same mask gates writes. This is provoked by a compare followed straight away by arithmetic in both timings. The writes that come out must follow the newly computed mask.

// File: rtl/vme_pkg.sv
// Shared op codes and state encoding for the masked vector executor.
package vme_pkg;
    localparam logic [2:0] OP_ADD  = 3'd0;
    localparam logic [2:0] OP_SUB  = 3'd1;
    localparam logic [2:0] OP_CGT  = 3'd2;
    localparam logic [2:0] OP_CEQ  = 3'd3;
    localparam logic [2:0] OP_MSET = 3'd4;

    typedef enum logic {ST_IDLE, ST_RUN} vme_state_t;
endpackage

// File: rtl/vme_first_set.sv
// Lowest-set-bit finder.
// Assumes W >= 2. Reports whether any bit is set and the index of the lowest one.
module vme_first_set #(
    parameter int W     = 64,
    localparam int IDXW = $clog2(W)
) (
    input  logic [W-1:0]    vec_i,
    output logic            found_o,
    output logic [IDXW-1:0] idx_o
);
    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/vme_elem_alu.sv
// Single-element datapath.
// Produces the wrapped sum or difference, and a compare flag
// (signed greater-than or equality, chosen by op).
module vme_elem_alu
    import vme_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              flag_o
);
    // Arithmetic result; subtraction only for the subtract code.
    always_comb begin
        res_o = (op_i == OP_SUB) ? (a_i - b_i) : (a_i + b_i);
    end

    // Compare result for the two compare codes.
    always_comb begin
        flag_o = (op_i == OP_CGT) ? ($signed(a_i) > $signed(b_i)) : (a_i == b_i);
    end
endmodule

// File: rtl/vme_executor.sv
// Masked vector element executor.
// Runs one op over elements 0..VL-1, one element per cycle.
// Arithmetic is gated by an internal mask and can skip disabled elements.
// Compares rewrite the mask. Source operands return combinationally for src_idx_o.
// Assumes MAX_VL is a power of two, at least 2.
module vme_executor
    import vme_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic              dense_i,
    input  logic [LEN_W-1:0]  vlen_i,
    output logic [IDX_W-1:0]  src_idx_o,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [MAX_VL-1:0] mask_o
);
    vme_state_t        state_q;
    logic [2:0]        op_q;
    logic              dense_q;
    logic              empty_q;
    logic [LEN_W-1:0]  vl_q;
    logic [IDX_W-1:0]  cur_q;
    logic [MAX_VL-1:0] mask_q;

    logic [LEN_W-1:0]  vl_in;
    logic [MAX_VL-1:0] start_elig, run_elig, ahead;
    logic              first_found, next_found;
    logic [IDX_W-1:0]  first_idx, next_idx;
    logic              is_arith, is_cmp, start_arith, skip_mode, one_shot, last;
    logic              cmp_wr, alu_flag;
    logic [DATA_W-1:0] alu_res;

    // Clamp the requested length to the vector capacity.
    always_comb vl_in = (vlen_i > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vlen_i;

    // Enabled elements: at start (requested length) and during a run (captured length).
    always_comb begin
        for (int i = 0; i < MAX_VL; i++) begin
            start_elig[i] = mask_q[i] && (LEN_W'(i) < vl_in);
            run_elig[i]   = mask_q[i] && (LEN_W'(i) < vl_q);
            ahead[i]      = run_elig[i] && (IDX_W'(i) > cur_q);
        end
    end

    vme_first_set #(.W(MAX_VL)) u_first (
        .vec_i(start_elig), .found_o(first_found), .idx_o(first_idx)
    );
    vme_first_set #(.W(MAX_VL)) u_next (
        .vec_i(ahead), .found_o(next_found), .idx_o(next_idx)
    );

    vme_elem_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i(op_q), .a_i(src_a_i), .b_i(src_b_i), .res_o(alu_res), .flag_o(alu_flag)
    );

    // Op class, single-cycle cases and the last-element decision.
    always_comb begin
        start_arith = (op_i == OP_ADD) || (op_i == OP_SUB);
        is_arith    = (op_q == OP_ADD) || (op_q == OP_SUB);
        is_cmp      = (op_q == OP_CGT) || (op_q == OP_CEQ);
        skip_mode   = is_arith && dense_q;
        one_shot    = !(is_arith || is_cmp) || (vl_q == '0) || (skip_mode && empty_q);
        if (one_shot)       last = 1'b1;
        else if (skip_mode) last = !next_found;
        else                last = (LEN_W'(cur_q) == vl_q - LEN_W'(1));
    end

    // Output drive: writes only for enabled arithmetic elements.
    always_comb begin
        busy_o    = (state_q == ST_RUN);
        done_o    = busy_o && last;
        wr_en_o   = busy_o && is_arith && !one_shot && mask_q[cur_q];
        cmp_wr    = busy_o && is_cmp && !one_shot;
        wr_idx_o  = cur_q;
        wr_data_o = alu_res;
        src_idx_o = busy_o ? cur_q : '0;
        mask_o    = mask_q;
    end

    // Sequencer: accept a start when idle, then step the element cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_ADD;
            dense_q <= 1'b0;
            empty_q <= 1'b0;
            vl_q    <= '0;
            cur_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start_i) begin
                state_q <= ST_RUN;
                op_q    <= op_i;
                dense_q <= dense_i;
                vl_q    <= vl_in;
                empty_q <= !first_found;
                cur_q   <= (dense_i && start_arith && first_found) ? first_idx : '0;
            end
        end else if (last) begin
            state_q <= ST_IDLE;
        end else begin
            cur_q <= skip_mode ? next_idx : cur_q + IDX_W'(1);
        end
    end

    // Mask register: filled by the set op, rewritten bit by bit by compares.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (busy_o && op_q == OP_MSET) begin
            mask_q <= '1;
        end else if (cmp_wr) begin
            mask_q[cur_q] <= alu_flag;
        end
    end

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !busy_o); // R3
    AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (src_idx_o > $past(src_idx_o))); // R4
    AST_DENSE_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && skip_mode && !one_shot && !done_o) |=> wr_en_o); // R4
    AST_ARITH_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && is_arith) |=> $stable(mask_o)); // R2
    AST_MSET_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_q == OP_MSET) |=> (mask_o == '1)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> (busy_o && $stable(op_q))); // R9
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && is_cmp) |-> !wr_en_o); // R6
endmodule

// File: tb/vme_executor_tb_top.sv
`timescale 1ns/1ps
module vme_executor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        dense_i = 1'b0;
    logic [6:0]  vlen_i = '0;
    logic [5:0]  src_idx_o;
    logic [15:0] src_a_i, src_b_i;
    logic        wr_en_o, busy_o, done_o;
    logic [5:0]  wr_idx_o;
    logic [15:0] wr_data_o;
    logic [63:0] mask_o;

    logic [15:0] va [64];
    logic [15:0] vb [64];
    logic [63:0] exp_mask;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always_comb begin
        src_a_i = va[src_idx_o];
        src_b_i = vb[src_idx_o];
    end

    vme_executor dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .dense_i(dense_i),
        .vlen_i(vlen_i), .src_idx_o(src_idx_o), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .done_o(done_o), .mask_o(mask_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_res(input logic [2:0] op, input int i);
        return (op == 3'd1) ? va[i] - vb[i] : va[i] + vb[i];
    endfunction

    function automatic bit model_flag(input logic [2:0] op, input int i);
        return (op == 3'd2) ? ($signed(va[i]) > $signed(vb[i])) : (va[i] == vb[i]);
    endfunction

    // Runs one op and checks writes, cycle count and the resulting mask.
    task automatic run_op(input logic [2:0] op, input bit dense, input int vl, input string req);
        int vle, exp_w, exp_cyc, cyc, nwr, last_idx;
        logic [63:0] new_mask;
        bit arith, cmp;
        vle = (vl > 64) ? 64 : vl;
        arith = (op <= 3'd1);
        cmp = (op == 3'd2) || (op == 3'd3);
        exp_w = 0;
        new_mask = exp_mask;
        for (int i = 0; i < vle; i++) begin
            if (arith && exp_mask[i]) exp_w++;
            if (cmp) new_mask[i] = model_flag(op, i);
        end
        if (op == 3'd4) new_mask = '1;
        if (arith && dense) exp_cyc = (exp_w == 0) ? 1 : exp_w;
        else if (arith || cmp) exp_cyc = (vle == 0) ? 1 : vle;
        else exp_cyc = 1;
        @(negedge clk);
        op_i = op; dense_i = dense; vlen_i = 7'(vl); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0; nwr = 0; last_idx = -1;
        while (1) begin
            cyc++;
            if (wr_en_o) begin
                nwr++;
                chk(int'(wr_idx_o) < vle && exp_mask[wr_idx_o] && int'(wr_idx_o) > last_idx,
                    req, "write index", wr_idx_o, last_idx + 1);
                chk(wr_data_o == model_res(op, int'(wr_idx_o)), req, "write data",
                    wr_data_o, model_res(op, int'(wr_idx_o)));
                last_idx = int'(wr_idx_o);
            end
            if (done_o || cyc > 200) break;
            @(negedge clk);
        end
        chk(cyc == exp_cyc, req, "busy cycles", cyc, exp_cyc);
        chk(nwr == exp_w, req, "write count", nwr, exp_w);
        @(negedge clk);
        chk(!busy_o, req, "busy after done", busy_o, 0);
        chk(mask_o == new_mask, req, "mask", mask_o, new_mask);
        exp_mask = new_mask;
    endtask

    // Loads a mask pattern through the equality compare over all 64 elements.
    task automatic set_mask(input logic [63:0] pat, input string req);
        for (int i = 0; i < 64; i++) begin
            va[i] = 16'($urandom);
            vb[i] = pat[i] ? va[i] : va[i] + 16'd1;
        end
        run_op(3'd3, 1'b0, 64, req);
    endtask

    task automatic rand_data();
        for (int i = 0; i < 64; i++) begin
            va[i] = 16'($urandom);
            vb[i] = ($urandom % 4 == 0) ? va[i] : 16'($urandom);
        end
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin va[i] = '0; vb[i] = '0; end
        exp_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !wr_en_o, "R1", "idle outputs", {busy_o, done_o, wr_en_o}, 0);
        chk(mask_o == '1, "R1", "reset mask", mask_o, 64'hFFFF_FFFF_FFFF_FFFF);

        // R2 R3 full-mask add, full sweep
        rand_data();
        run_op(3'd0, 1'b0, 64, "R2");
        // R6 equality compare, then R3 subtract and R4 skipping add on the new mask
        set_mask({$urandom, $urandom}, "R6");
        rand_data();
        run_op(3'd1, 1'b0, 64, "R3");
        run_op(3'd0, 1'b1, 64, "R4");
        // R7 fill, then R6 signed compare over 40 elements in skip mode (mode ignored)
        run_op(3'd4, 1'b1, 64, "R7");
        for (int i = 0; i < 64; i++) begin
            va[i] = 16'($urandom); vb[i] = (i % 3 == 0) ? 16'h8000 : 16'h7FFF;
        end
        run_op(3'd2, 1'b1, 40, "R6");
        // R8 bits above VL are set but must not cause writes
        rand_data();
        run_op(3'd0, 1'b1, 20, "R8");
        run_op(3'd1, 1'b0, 20, "R8");
        // R5 empty mask in both timings, and VL of zero
        set_mask(64'h0, "R5");
        rand_data();
        run_op(3'd0, 1'b1, 64, "R5");
        run_op(3'd0, 1'b0, 64, "R5");
        run_op(3'd4, 1'b0, 0, "R7");
        run_op(3'd0, 1'b1, 0, "R5");
        run_op(3'd2, 1'b0, 0, "R5");
        // R4 single enabled element at the top
        set_mask(64'h8000_0000_0000_0000, "R4");
        rand_data();
        run_op(3'd0, 1'b1, 64, "R4");
        // R8 length clamp
        run_op(3'd4, 1'b0, 1, "R7");
        run_op(3'd1, 1'b0, 100, "R8");
        run_op(3'd1, 1'b1, 127, "R8");
        // R9 reserved codes
        set_mask({$urandom, $urandom}, "R6");
        run_op(3'd5, 1'b0, 64, "R9");
        run_op(3'd7, 1'b1, 30, "R9");

        // R9 start raised exactly in the done cycle is ignored
        @(negedge clk);
        op_i = 3'd0; dense_i = 1'b0; vlen_i = 7'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 10 && !done_o; k++) @(negedge clk);
        chk(done_o, "R9", "done reached", done_o, 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o && !wr_en_o, "R9", "start in done cycle", {busy_o, wr_en_o}, 0);
        @(negedge clk);
        chk(!busy_o, "R9", "still idle", busy_o, 0);

        // Random mix over all op codes and both timings
        for (int n = 0; n < 40; n++) begin
            rand_data();
            run_op(3'($urandom % 8), 1'($urandom), int'($urandom % 72),
                   "R2 R3 R4 R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule